// File: doc/BRIEF.md
# Interleaved Read Stress Command Sequencer

This block drives the command pins of a four-bank double-data-rate SDRAM with a fixed, repeating command stream for current and stress measurements. It issues one command per clock as active-low chip-select, row-strobe, column-strobe and write-enable lines, together with a bank address and a multiplexed address. In the two interleaved modes, each bank's ACTIVATE is threaded between the auto-precharging READs of the bank before it, so that every bank is kept busy. Two single-bank modes instead cycle one bank through activate, read and precharge. Row and column addresses are drawn from an internal 16-bit maximal-length LFSR. The LFSR is loaded from a seed at start and steps once per pattern period, so each repetition hits a new address.

Software or a test controller picks a mode, gives a seed and pulses start. The pattern then repeats until stop is seen. The sequencer always completes the period it is in before it falls back to deselect. While a pattern runs, `valid_o` is high and serves as the busy flag.

Top module: `ilv_rd_seq`

## Requirements
- R1: Out of reset and whenever idle, the block drives deselect (all four command lines high), bank 0, address 0, and `valid_o` low.
- R2: A high `start_i` at a rising edge while idle makes the next cycle slot 0 of the pattern (ACTIVATE to bank 0), with `valid_o` high. The mode and the seed are captured at that edge. `start_i` while running has no effect.
- R3: Mode 0 repeats an 8-slot period. Slots 0,2,4,6 activate banks 0,1,2,3. Slots 3,5,7 read banks 0,1,2. Slot 1 reads bank 3, except in the first period, where it is a NOP.
- R4: Mode 1 repeats a 10-slot period. Slots 0,2,4,6 activate banks 0..3. Slots 3,5,7,9 read banks 0..3. Slots 1 and 8 are NOPs.
- R5: Mode 2 repeats a 9-slot period on bank 0. It has ACTIVATE at slot 0, READ at slot 3 and PRECHARGE at slot 5, and NOPs elsewhere.
- R6: Mode 3 repeats a 7-slot period on bank 0. It has ACTIVATE at slot 0, READ at slot 2 and PRECHARGE at slot 5, and NOPs elsewhere.
- R7: Encoding as {cs_no,ras_no,cas_no,we_no}: ACTIVATE 0011, READ 0101, PRECHARGE 0010, NOP 0111, deselect 1111.
- R8: ACTIVATE drives the address with LFSR bits [12:0]. READ drives LFSR bits [15:8] on address bits [9:2], with bits [1:0] zero, and sets bit 10 (auto-precharge) in modes 0 and 1 but clears it in modes 2 and 3. PRECHARGE and NOP drive address 0. The bank is 0 on NOP and in modes 2 and 3.
- R9: At start, the LFSR loads the seed, or 0x0001 if the seed is zero. At the end of each period that does not stop, it shifts left one place, and the new bit 0 is bit15^bit13^bit12^bit10.
- R10: A high `stop_i` while running lets the current period finish and then returns the block to idle. A stop seen in the last slot ends the run at that same boundary.
- R11: Changes on `mode_i` and `seed_i` while running have no effect on the stream.
- R12: No two consecutive cycles carry ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin pattern (sampled while idle) |
| stop_i | input | 1 | End after current period |
| mode_i | input | 2 | 0: four-bank 8-slot, 1: four-bank 10-slot, 2: one-bank 9-slot, 3: one-bank 7-slot |
| seed_i | input | 16 | LFSR seed |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Multiplexed row/column address |
| valid_o | output | 1 | Pattern slot being emitted (busy) |

## Verification
The assertions assume that `start_i`, `stop_i`, `mode_i` and `seed_i` are synchronous to `clk_i` and hold steady around each rising edge. They place no limits on the order or overlap of these inputs: start and stop may arrive together, and mode or seed may change at any time. The stimulus changes inputs only on falling edges. It covers every mode and a zero seed, and it includes a start during a run, mode and seed changes mid-run, a stop in the first slot and in the last slot, and start and stop raised together while idle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  parameter int LFSR_W = 16;
  parameter int SLOT_W = 4;

  typedef enum logic [1:0] {
    MODE_ILV2 = 2'd0,
    MODE_ILV3 = 2'd1,
    MODE_ONE9 = 2'd2,
    MODE_ONE7 = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CMD_DES,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_PRE
  } cmd_e;

  function automatic logic [SLOT_W-1:0] last_slot(mode_e m);
    case (m)
      MODE_ILV2: return SLOT_W'(7);
      MODE_ILV3: return SLOT_W'(9);
      MODE_ONE9: return SLOT_W'(8);
      default:   return SLOT_W'(6);
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] v);
    return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction
endpackage

// File: rtl/ilv_lfsr.sv
module ilv_lfsr
  import ilv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= LFSR_W'(1);
    else if (load_i) q_o <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (adv_i)  q_o <= lfsr_step(q_o);
  end

  // R9
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o != '0);

  // R9
  lfsr_zero_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> q_o == LFSR_W'(1));
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  mode_e             mode_i,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o,
  output mode_e             mode_o,
  output logic              primed_o,
  output logic              load_o,
  output logic              adv_o
);
  logic stop_pend_q;
  logic stop_now;
  logic at_end;

  assign at_end   = run_o && (slot_o == last_slot(mode_o));
  assign stop_now = stop_pend_q | stop_i;
  assign load_o   = !run_o && start_i;
  assign adv_o    = at_end && !stop_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o       <= 1'b0;
      slot_o      <= '0;
      mode_o      <= MODE_ILV2;
      primed_o    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (load_o) begin
      run_o       <= 1'b1;
      slot_o      <= '0;
      mode_o      <= mode_i;
      primed_o    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (run_o) begin
      if (at_end) begin
        slot_o      <= '0;
        primed_o    <= 1'b1;
        stop_pend_q <= 1'b0;
        if (stop_now) run_o <= 1'b0;
      end else begin
        slot_o      <= slot_o + SLOT_W'(1);
        stop_pend_q <= stop_now;
      end
    end
  end

  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run_o) |=> (run_o && slot_o == '0 && !primed_o));

  // R10
  stop_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && stop_now) |=> !run_o);

  // R10
  end_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(at_end));

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(mode_o));
endmodule

// File: rtl/ilv_decode.sv
module ilv_decode
  import ilv_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int COL_W   = 10,
  parameter int BURST_W = 2,
  parameter int AP_BIT  = 10
) (
  input  logic              run_i,
  input  mode_e             mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              primed_i,
  input  logic [LFSR_W-1:0] lfsr_i,
  output cmd_e              cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int COL_HI = COL_W - BURST_W;

  logic [ADDR_W-1:0] row_a;
  logic [ADDR_W-1:0] col_a;
  logic [SLOT_W-1:0] rd_idx;
  logic              ap;

  assign row_a  = lfsr_i[ADDR_W-1:0];
  assign col_a  = ADDR_W'({lfsr_i[LFSR_W-1 -: COL_HI], {BURST_W{1'b0}}});
  assign rd_idx = slot_i - SLOT_W'(3);
  assign ap     = (mode_i == MODE_ILV2) || (mode_i == MODE_ILV3);

  always_comb begin
    cmd_o = CMD_DES;
    ba_o  = '0;
    if (run_i) begin
      cmd_o = CMD_NOP;
      case (mode_i)
        MODE_ILV2: begin
          if (!slot_i[0]) begin
            cmd_o = CMD_ACT;
            ba_o  = slot_i[2:1];
          end else if (slot_i != SLOT_W'(1) || primed_i) begin
            cmd_o = CMD_RD;
            ba_o  = slot_i[2:1] - 2'd1;
          end
        end
        MODE_ILV3: begin
          if (!slot_i[0] && slot_i < SLOT_W'(8)) begin
            cmd_o = CMD_ACT;
            ba_o  = slot_i[2:1];
          end else if (slot_i[0] && slot_i != SLOT_W'(1)) begin
            cmd_o = CMD_RD;
            ba_o  = rd_idx[2:1];
          end
        end
        MODE_ONE9: begin
          if (slot_i == SLOT_W'(0))      cmd_o = CMD_ACT;
          else if (slot_i == SLOT_W'(3)) cmd_o = CMD_RD;
          else if (slot_i == SLOT_W'(5)) cmd_o = CMD_PRE;
        end
        default: begin
          if (slot_i == SLOT_W'(0))      cmd_o = CMD_ACT;
          else if (slot_i == SLOT_W'(2)) cmd_o = CMD_RD;
          else if (slot_i == SLOT_W'(5)) cmd_o = CMD_PRE;
        end
      endcase
    end
  end

  always_comb begin
    addr_o = '0;
    if (cmd_o == CMD_ACT) addr_o = row_a;
    else if (cmd_o == CMD_RD) begin
      addr_o         = col_a;
      addr_o[AP_BIT] = ap;
    end
  end
endmodule

// File: rtl/ilv_rd_seq.sv
module ilv_rd_seq
  import ilv_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int COL_W   = 10,
  parameter int BURST_W = 2,
  parameter int AP_BIT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        mode_i,
  input  logic [15:0]       seed_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic              run;
  logic [SLOT_W-1:0] slot;
  mode_e             mode_q;
  logic              primed;
  logic              load;
  logic              adv;
  logic [LFSR_W-1:0] lfsr;
  cmd_e              cmd;

  ilv_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mode_i   (mode_e'(mode_i)),
    .run_o    (run),
    .slot_o   (slot),
    .mode_o   (mode_q),
    .primed_o (primed),
    .load_o   (load),
    .adv_o    (adv)
  );

  ilv_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .seed_i (seed_i),
    .q_o    (lfsr)
  );

  ilv_decode #(
    .ADDR_W  (ADDR_W),
    .COL_W   (COL_W),
    .BURST_W (BURST_W),
    .AP_BIT  (AP_BIT)
  ) u_dec (
    .run_i    (run),
    .mode_i   (mode_q),
    .slot_i   (slot),
    .primed_i (primed),
    .lfsr_i   (lfsr),
    .cmd_o    (cmd),
    .ba_o     (ba_o),
    .addr_o   (addr_o)
  );

  always_comb begin
    case (cmd)
      CMD_NOP: {cs_no, ras_no, cas_no, we_no} = 4'b0111;
      CMD_ACT: {cs_no, ras_no, cas_no, we_no} = 4'b0011;
      CMD_RD:  {cs_no, ras_no, cas_no, we_no} = 4'b0101;
      CMD_PRE: {cs_no, ras_no, cas_no, we_no} = 4'b0010;
      default: {cs_no, ras_no, cas_no, we_no} = 4'b1111;
    endcase
  end

  assign valid_o = run;

  // R12
  act_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !ras_no && cas_no && we_no) |=> !(!cs_no && !ras_no && cas_no && we_no));

  // R1
  idle_des_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cs_no && addr_o == '0));
endmodule

// File: tb/ilv_rd_seq_tb_top.sv
module ilv_rd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] seed = 16'h0;
  logic        cs_n, ras_n, cas_n, we_n, valid;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #4 clk = ~clk;

  ilv_rd_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .stop_i (stop),
    .mode_i (mode), .seed_i (seed), .cs_no (cs_n), .ras_no (ras_n),
    .cas_no (cas_n), .we_no (we_n), .ba_o (ba), .addr_o (addr), .valid_o (valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_run = 0, m_mode = 0, m_slot = 0, m_primed = 0, m_stopp = 0;
  int m_lfsr = 1;

  function automatic int plen(int m);
    case (m) 0: return 8; 1: return 10; 2: return 9; default: return 7; endcase
  endfunction

  function automatic int lnext(int v);
    int fb;
    fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
    return ((v << 1) | fb) & 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_slot = 0; m_primed = 0; m_stopp = 0; m_lfsr = 1; m_mode = 0;
    end else if (m_run == 0) begin
      if (start) begin
        m_run = 1; m_slot = 0; m_primed = 0; m_stopp = 0;
        m_mode = int'(mode);
        m_lfsr = (seed == 16'h0) ? 1 : int'(seed);
      end
    end else begin
      int stp;
      stp = (m_stopp != 0 || stop) ? 1 : 0;
      if (m_slot == plen(m_mode) - 1) begin
        m_slot = 0; m_stopp = 0;
        if (stp != 0) m_run = 0;
        else begin m_lfsr = lnext(m_lfsr); m_primed = 1; end
      end else begin
        m_slot++; m_stopp = stp;
      end
    end
  end

  // kind: 0 des, 1 nop, 2 act, 3 rd, 4 pre
  function automatic logic [19:0] expect_vec();
    int k, b, a;
    logic [3:0] pins;
    k = 0; b = 0; a = 0;
    if (m_run != 0) begin
      k = 1;
      case (m_mode)
        0: if (m_slot % 2 == 0) begin k = 2; b = m_slot / 2; end
           else if (m_slot != 1 || m_primed != 0) begin k = 3; b = ((m_slot - 1) / 2 + 3) % 4; end
        1: if (m_slot < 8 && m_slot % 2 == 0) begin k = 2; b = m_slot / 2; end
           else if (m_slot % 2 == 1 && m_slot != 1) begin k = 3; b = (m_slot - 3) / 2; end
        2: k = (m_slot == 0) ? 2 : (m_slot == 3) ? 3 : (m_slot == 5) ? 4 : 1;
        default: k = (m_slot == 0) ? 2 : (m_slot == 2) ? 3 : (m_slot == 5) ? 4 : 1;
      endcase
    end
    if (k == 2) a = m_lfsr & 16'h1FFF;
    if (k == 3) a = (((m_lfsr >> 8) & 8'hFF) << 2) | ((m_mode < 2) ? 16'h0400 : 0);
    case (k)
      0: pins = 4'b1111; 1: pins = 4'b0111; 2: pins = 4'b0011;
      3: pins = 4'b0101; default: pins = 4'b0010;
    endcase
    return {pins, b[1:0], a[12:0], (m_run != 0)};
  endfunction

  logic prev_act = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      logic [19:0] got, exp;
      string tag;
      got = {cs_n, ras_n, cas_n, we_n, ba, addr, valid};
      exp = expect_vec();
      n_chk++;
      if (got !== exp) begin
        if (got[0] !== exp[0]) tag = exp[0] ? "R2" : "R10";
        else if (exp[0] == 1'b0) tag = "R1";
        else if (got[19:16] !== exp[19:16])
          case (m_mode) 0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5"; default: tag = "R6"; endcase
        else tag = "R8";
        n_bad++;
        $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
      end
      // R12: consecutive activates
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0011) begin
        n_chk++;
        if (prev_act) begin
          n_bad++;
          $display("FAIL R12 got=ACT,ACT exp=gap");
        end
      end
      prev_act = ({cs_n, ras_n, cas_n, we_n} == 4'b0011);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(logic [1:0] md, logic [15:0] sd);
    @(negedge clk);
    mode = md; seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    while (m_run != 0) @(negedge clk);
    tick(3);
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    // R1: reset and idle deselect, R7 deselect code
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R3, R7, R8, R9: mode 0, several periods then mid-period stop (R10)
    launch(2'd0, 16'hACE1);
    tick(30);
    halt();
    // R4 with R11 (mode/seed changed mid-run) and R2 (start while running ignored)
    launch(2'd1, 16'h1234);
    tick(5);
    mode = 2'd2; seed = 16'hFFFF; start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(25);
    halt();
    // R5 with zero seed: R9 substitutes 0x0001
    launch(2'd2, 16'h0000);
    tick(20);
    halt();
    // R6, stop raised in the last slot ends at that boundary (R10)
    launch(2'd3, 16'h8001);
    tick(10);
    while (m_slot != 6) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    tick(4);
    // R2: start and stop together while idle -> stop ignored, run starts
    @(negedge clk);
    mode = 2'd0; seed = 16'h00FF; start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    tick(12);
    halt();
    // R3: stop in first slot of mode 0 -> one period only, slot 1 stays NOP
    launch(2'd0, 16'h5A5A);
    halt();
    // R8: single-bank reads clear auto-precharge
    launch(2'd3, 16'hF00F);
    tick(15);
    halt();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule